// File: doc/BRIEF.md
# PDM Microphone Decimator

This block turns the one-bit density stream of a digital microphone into signed PCM samples. It derives the microphone bit clock from the system clock with a fixed integer divider and captures the data line once per bit, at the rising edge of that generated clock. Each captured bit enters a multi-stage cascaded integrator-comb filter as a non-negative two-bit value, either 0 or 1. The filter decimates by a power of two. Its width grows by the filter gain, so no sample can overflow.

Because the input is unipolar, the decimated stream sits on a large positive offset. A first-order high-pass filter, built from a shift and a subtract, removes that offset. Both the raw filter result and the offset-free sample are presented together. A single-cycle valid pulse marks each new sample. With the default divider and a decimation of 64, a 2.4 MHz bit clock yields 37.5 kHz audio.

Top module: `pdm_cic_decim`

## Requirements
- R1: `mic_clk_o` is low while reset is held. After reset it is a square wave that spends exactly HALF_DIV system cycles high and HALF_DIV system cycles low.
- R2: The data line is captured on the rising edge of `mic_clk_o`. A level present only during the high half of the bit clock is never seen.
- R3: Exactly one sample is produced for every DECIM captured bits. `pcm_valid_o` is high for one system cycle, and successive pulses are DECIM*2*HALF_DIV system cycles apart.
- R4: When the input repeats a 64-bit pattern containing k ones, the settled value of `cic_o` equals k*64^4, which is k*2^24. An all-ones input gives 2^30 and an all-zeros input gives 0.
- R5: The integrator registers wrap in two's complement, and the output stays exact after inputs long enough to wrap them. After 1280 consecutive one-bits, `cic_o` is still 2^30.
- R6: `cic_o` is never negative and never exceeds 2^30.
- R7: Each offset-free sample is formed as `pcm = x - xp + yp - (yp >>> 8)`, with 32-bit wrap-around. Here x is the `cic_o` value of the same pulse, xp is the previous `cic_o`, yp is the previous `pcm_o`, and `>>>` is an arithmetic shift. Both xp and yp start at zero after reset.
- R8: Reset drives `cic_o`, `pcm_o` and `pcm_valid_o` to zero. It also clears all filter state, so the first sample after a reset taken in the middle of a run, with a zero input, is 0 on both outputs.
- R9: `pcm_o` and `cic_o` change only in a cycle where `pcm_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mic_clk_o | output | 1 | Generated microphone bit clock |
| mic_data_i | input | 1 | Density-modulated data from the microphone |
| cic_o | output | OUT_W (32) | Raw decimated filter output, signed |
| pcm_o | output | OUT_W (32) | Offset-free PCM sample, signed |
| pcm_valid_o | output | 1 | One-cycle strobe marking a new sample on both outputs |

## Verification
The filter is driven with repeating 64-bit patterns of different densities: all ones, all zeros, a single one, half and quarter duty, a 32-bit block, and all but one bit. Because the settled output must scale with the count of ones alone, a wrong gain, a dropped or duplicated bit, or a wrong stage count each shows up as a different value. Two timing variants of the all-ones stream, one valid only in the low half of the bit clock and one valid only in the high half, separate rising-edge capture from falling-edge capture. A long all-ones run forces the integrators to wrap, and a reset taken mid-run followed by silence exposes any state the reset fails to clear.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;
  // Width growth of an N-stage decimator with differential delay one
  function automatic int cic_width(input int in_w, input int stages, input int decim);
    return in_w + stages * $clog2(decim);
  endfunction
endpackage

// File: rtl/pdm_bitclk_gen.sv
module pdm_bitclk_gen #(
  parameter int HALF_DIV = 52
) (
  input  logic clk,
  input  logic rst,
  input  logic data_i,
  output logic mic_clk_o,
  output logic bit_o,
  output logic bit_vld_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      clk_q     <= 1'b0;
      bit_o     <= 1'b0;
      bit_vld_o <= 1'b0;
    end else begin
      bit_vld_o <= 1'b0;
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        clk_q <= ~clk_q;
        if (!clk_q) begin
          // generated clock rises at this edge: capture the data line
          bit_o     <= data_i;
          bit_vld_o <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign mic_clk_o = clk_q;
endmodule

// File: rtl/cic_decim.sv
module cic_decim #(
  parameter int STAGES = 5,
  parameter int DECIM  = 64,
  parameter int OUT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_i,
  input  logic                    bit_vld_i,
  output logic signed [OUT_W-1:0] sum_o,
  output logic                    sum_vld_o
);
  localparam int DW = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DECIM - 1);

  logic signed [OUT_W-1:0] integ_q [STAGES];
  logic signed [OUT_W-1:0] dly_q   [STAGES];
  logic signed [OUT_W-1:0] comb_v  [STAGES+1];
  logic signed [OUT_W-1:0] sample_ext;
  logic [DW-1:0]           dec_q;
  logic                    stb_q;

  // unipolar two-bit word {0, bit}, zero-extended to the register width
  assign sample_ext = {{(OUT_W-1){1'b0}}, bit_i};

  // integrators at the bit rate, wrapping arithmetic
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) integ_q[s] <= '0;
    end else if (bit_vld_i) begin
      for (int s = 0; s < STAGES; s++) begin
        if (s == 0) integ_q[s] <= integ_q[s] + sample_ext;
        else        integ_q[s] <= integ_q[s] + integ_q[s-1];
      end
    end
  end

  // decimation counter; strobe lands once the last bit is integrated
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= bit_vld_i && (dec_q == DLAST);
      if (bit_vld_i) dec_q <= (dec_q == DLAST) ? '0 : dec_q + 1'b1;
    end
  end

  // comb chain at the decimated rate
  always_comb begin
    comb_v[0] = integ_q[STAGES-1];
    for (int s = 0; s < STAGES; s++) comb_v[s+1] = comb_v[s] - dly_q[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) dly_q[s] <= '0;
      sum_o     <= '0;
      sum_vld_o <= 1'b0;
    end else begin
      sum_vld_o <= stb_q;
      if (stb_q) begin
        for (int s = 0; s < STAGES; s++) dly_q[s] <= comb_v[s];
        sum_o <= comb_v[STAGES];
      end
    end
  end
endmodule

// File: rtl/dc_block.sv
module dc_block #(
  parameter int W     = 32,
  parameter int SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] x_i,
  input  logic                x_vld_i,
  output logic signed [W-1:0] raw_o,
  output logic signed [W-1:0] y_o,
  output logic                y_vld_o
);
  logic signed [W-1:0] xp_q;
  logic signed [W-1:0] y_next;

  // pole at 1 - 2^-SHIFT via shift-and-subtract
  assign y_next = x_i - xp_q + y_o - (y_o >>> SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      xp_q    <= '0;
      y_o     <= '0;
      raw_o   <= '0;
      y_vld_o <= 1'b0;
    end else begin
      y_vld_o <= x_vld_i;
      if (x_vld_i) begin
        xp_q  <= x_i;
        y_o   <= y_next;
        raw_o <= x_i;
      end
    end
  end
endmodule

// File: rtl/pdm_cic_decim.sv
module pdm_cic_decim
  import pdm_cic_pkg::*;
#(
  parameter int  HALF_DIV = 52,
  parameter int  STAGES   = 5,
  parameter int  DECIM    = 64,
  parameter int  IN_W     = 2,
  parameter int  DC_SHIFT = 8,
  localparam int OUT_W    = cic_width(IN_W, STAGES, DECIM)
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic                    mic_clk_o,
  input  logic                    mic_data_i,
  output logic signed [OUT_W-1:0] cic_o,
  output logic signed [OUT_W-1:0] pcm_o,
  output logic                    pcm_valid_o
);
  logic                    bit_q;
  logic                    bit_vld;
  logic signed [OUT_W-1:0] sum;
  logic                    sum_vld;

  pdm_bitclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .data_i    (mic_data_i),
    .mic_clk_o (mic_clk_o),
    .bit_o     (bit_q),
    .bit_vld_o (bit_vld)
  );

  cic_decim #(.STAGES(STAGES), .DECIM(DECIM), .OUT_W(OUT_W)) u_cic (
    .clk       (clk),
    .rst       (rst),
    .bit_i     (bit_q),
    .bit_vld_i (bit_vld),
    .sum_o     (sum),
    .sum_vld_o (sum_vld)
  );

  dc_block #(.W(OUT_W), .SHIFT(DC_SHIFT)) u_dc (
    .clk     (clk),
    .rst     (rst),
    .x_i     (sum),
    .x_vld_i (sum_vld),
    .raw_o   (cic_o),
    .y_o     (pcm_o),
    .y_vld_o (pcm_valid_o)
  );
endmodule

// File: rtl/pdm_cic_decim_chk.sv
module pdm_cic_decim_chk #(
  parameter int HALF_DIV = 52,
  parameter int DECIM    = 64,
  parameter int OUT_W    = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    mic_clk_o,
  input logic signed [OUT_W-1:0] cic_o,
  input logic signed [OUT_W-1:0] pcm_o,
  input logic                    pcm_valid_o
);
  localparam int PERIOD = DECIM * 2 * HALF_DIV;

  int   gap_cnt;
  logic seen;
  int   hold_cnt;
  logic prev_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= 0;
      seen    <= 1'b0;
    end else if (pcm_valid_o) begin
      gap_cnt <= 0;
      seen    <= 1'b1;
    end else begin
      gap_cnt <= gap_cnt + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= 0;
      prev_clk <= 1'b0;
    end else begin
      prev_clk <= mic_clk_o;
      hold_cnt <= (mic_clk_o != prev_clk) ? 0 : hold_cnt + 1;
    end
  end

  p_clk_half_r1: assert property (@(posedge clk) disable iff (rst)
    hold_cnt <= HALF_DIV);

  p_pulse_width_r3: assert property (@(posedge clk) disable iff (rst)
    pcm_valid_o |=> !pcm_valid_o);

  p_pulse_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (pcm_valid_o && seen) |-> (gap_cnt == PERIOD - 1));

  p_range_r6: assert property (@(posedge clk) disable iff (rst)
    pcm_valid_o |-> (cic_o >= 0 && cic_o <= (OUT_W'(1) << (OUT_W - 2))));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !pcm_valid_o |-> ($stable(pcm_o) && $stable(cic_o)));
endmodule

bind pdm_cic_decim pdm_cic_decim_chk #(
  .HALF_DIV(HALF_DIV), .DECIM(DECIM), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .mic_clk_o(mic_clk_o),
  .cic_o(cic_o), .pcm_o(pcm_o), .pcm_valid_o(pcm_valid_o)
);

// File: tb/tb_pdm_cic_decim.sv
`timescale 1ns/1ps
module tb_pdm_cic_decim;
  localparam int HALF = 2;
  localparam int TCLK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mic_clk_o;
  logic signed [31:0] cic_o, pcm_o;
  logic pcm_valid_o;

  logic [63:0] pat = '0;
  int   mode = 0;      // 0 full bit, 1 low half only, 2 high half only
  logic quiet = 1'b0;
  logic drv_bit = 1'b0;
  int   bidx = 0;
  logic mic_in;
  assign mic_in = drv_bit & ~quiet;

  always #(TCLK/2) clk = ~clk;

  pdm_cic_decim #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .mic_clk_o(mic_clk_o), .mic_data_i(mic_in),
    .cic_o(cic_o), .pcm_o(pcm_o), .pcm_valid_o(pcm_valid_o)
  );

  int nchk = 0, nfail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit driver, changes 1 ns after each bit-clock edge
  always @(mic_clk_o) begin
    #1;
    if (!mic_clk_o) begin
      drv_bit = (mode == 2) ? 1'b0 : pat[bidx];
      bidx = (bidx + 1) % 64;
    end else begin
      if (mode == 1)      drv_bit = 1'b0;
      else if (mode == 2) drv_bit = pat[bidx];
    end
  end

  // output monitor with an independent model of the offset remover (R7)
  logic signed [31:0] x_m = 0, y_m = 0, e_m, last_cic = 0, last_pcm = 0, pcm_hold = 0, cic_hold = 0;
  int   vcount = 0;
  time  t_last = 0, t_prev = 0;
  logic prev_valid = 1'b0, pulse_err = 1'b0, hold_err = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      x_m = 0; y_m = 0;
    end else if (pcm_valid_o) begin
      e_m = cic_o - x_m + y_m - (y_m >>> 8);
      chk("R7", pcm_o, e_m);
      x_m = cic_o; y_m = e_m;
      last_cic = cic_o; last_pcm = pcm_o;
      vcount++;
      t_prev = t_last; t_last = $time;
      if (prev_valid) pulse_err = 1'b1;
    end
    if (!rst && !pcm_valid_o && (pcm_o !== pcm_hold || cic_o !== cic_hold)) hold_err = 1'b1;
    pcm_hold = pcm_o; cic_hold = cic_o;
    prev_valid = pcm_valid_o;
  end

  task automatic wait_valids(input int n);
    int target;
    target = vcount + n;
    while (vcount < target) @(posedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [63:0] pat;
    logic [1:0]  mode;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 32'h4000_0000},
    '{64'h0000_0000_0000_0000, 2'd0, 32'h0000_0000},
    '{64'hAAAA_AAAA_AAAA_AAAA, 2'd0, 32'h2000_0000},
    '{64'h1111_1111_1111_1111, 2'd0, 32'h1000_0000},
    '{64'hFFFF_FFFF_0000_0000, 2'd0, 32'h2000_0000},
    '{64'h0000_0000_0000_0001, 2'd0, 32'h0100_0000},
    '{64'h0000_0000_0000_00FF, 2'd0, 32'h0800_0000},
    '{64'hFFFF_FFFF_FFFF_FFFE, 2'd0, 32'h3F00_0000},
    '{64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 32'h4000_0000},
    '{64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 32'h0000_0000}
  };

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    time t0, t1, t2;
    repeat (5) @(negedge clk);
    // R8 / R1: reset state
    chk("R8", {31'b0, pcm_valid_o}, 32'd0);
    chk("R8", pcm_o, 32'd0);
    chk("R8", cic_o, 32'd0);
    chk("R1", {31'b0, mic_clk_o}, 32'd0);
    rst = 1'b0;

    // R1: bit clock halves
    @(posedge mic_clk_o); t0 = $time;
    @(negedge mic_clk_o); t1 = $time;
    @(posedge mic_clk_o); t2 = $time;
    chk("R1", 32'(t1 - t0), 32'(HALF * TCLK));
    chk("R1", 32'(t2 - t1), 32'(HALF * TCLK));

    // R4 / R2: pattern table
    for (int i = 0; i < 10; i++) begin
      pat = VECS[i].pat;
      mode = int'(VECS[i].mode);
      wait_valids(10);
      chk((VECS[i].mode != 2'd0) ? "R2" : "R4", last_cic, VECS[i].exp);
    end

    // R3: sample spacing and pulse width
    chk("R3", 32'(t_last - t_prev), 32'(64 * 2 * HALF * TCLK));
    chk("R3", {31'b0, pulse_err}, 32'd0);

    // R5: long all-ones run, integrators wrap
    pat = '1; mode = 0;
    wait_valids(20);
    chk("R5", last_cic, 32'h4000_0000);

    // R8: reset mid-run, then silence
    @(negedge clk); rst = 1'b1; quiet = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", pcm_o, 32'd0);
    chk("R8", cic_o, 32'd0);
    rst = 1'b0;
    wait_valids(1);
    chk("R8", last_cic, 32'd0);
    chk("R8", last_pcm, 32'd0);

    // R9: outputs held between strobes
    chk("R9", {31'b0, hold_err}, 32'd0);
    summary();
  end
endmodule